// File: doc/BRIEF.md
# Flash Sector Lockdown and Security Register Controller

This block holds the write-protection state of a word-addressed flash array and a 128-bit security register. A 19-bit word address is mapped onto 23 erase sectors with a top-boot layout: fifteen large sectors of 32K words fill the low part of the space, and eight small sectors of 4K words fill the top 32K words. Sector locks are set one at a time through a request port. They cannot be removed by any request; only reset clears them.

The command decoder asks the query port whether a program or erase may proceed. A program or single-sector erase aimed at a locked sector is refused in the same cycle. A whole-array erase is never refused. Instead it receives a mask of the sectors it may erase, so locked sectors are skipped without any failure.

The security register has two 64-bit halves. The factory half is a build-time constant. The user half can only have bits cleared, and it can be frozen for good by a lock request. Identification-mode reads of sector status words and of the security register go through a read port with one cycle of latency.

Top module: `flock_ctrl`

## Requirements
- R1: After reset every sector is unlocked. Every user-half word reads 16'hFFFF, and the security lock status word reads 16'h0002.
- R2: Word addresses 0x00000–0x77FFF map to sectors 0–14 in 32K-word steps. Addresses 0x78000–0x7FFFF map to sectors 15–22 in 4K-word steps.
- R3: A request with `req_op`=1 (lock sector) locks exactly the sector that contains `req_addr`. The lock shows on `qry_locked` from the next clock edge onward.
- R4: A sector lock stays set through any later request, including a repeated lock request. Only reset clears it.
- R5: With `qry_valid`=1 and `qry_op`=0 (program) or 1 (sector erase), `qry_refuse` is 1 in the same cycle exactly when the addressed sector is locked. With `qry_valid`=0, `qry_refuse` is 0.
- R6: With `qry_valid`=1 and `qry_op`=2 (chip erase), `qry_refuse` is 0, and `erase_mask` bit i is 1 exactly when sector i is unlocked. In every other case `erase_mask` is 0, and `qry_op`=3 never refuses.
- R7: A read with `rd_space`=0 returns, one cycle later, bit 0 = lock state of the sector holding `rd_addr` when the word offset within that sector is 2. All other bits are 0, and all bits are 0 at any other offset.
- R8: A read with `rd_space`=1 uses `rd_addr[3:0]` as the index. Indices 0–3 return the factory half, lowest 16 bits first. Indices 4–7 return the user half in the same order. Index 8 returns the lock status word (16'h0002 writable, 16'h0000 locked). Any other index returns 0.
- R9: A request with `req_op`=2 (program security word) sets user-half word `req_addr[1:0]` to its old value AND `req_data`. It can never turn a 0 bit into a 1.
- R10: A request with `req_op`=3 locks the user half only when `req_data[1]`=0; with `req_data[1]`=1 it has no effect. Once locked, program requests leave the user half unchanged.
- R11: Reset clears every sector lock, the user-half lock and the user-half contents back to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 none, 1 lock sector, 2 program security word, 3 lock user half |
| req_addr | input | 19 | Word address (sector select, or security word index in bits 1:0) |
| req_data | input | 16 | Program data or lock data |
| qry_valid | input | 1 | Query strobe |
| qry_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| qry_addr | input | 19 | Query word address |
| qry_locked | output | 1 | Lock state of the sector holding `qry_addr` |
| qry_refuse | output | 1 | Program or sector erase refused |
| erase_mask | output | 23 | Sectors a chip erase may clear |
| rd_en | input | 1 | Read strobe |
| rd_space | input | 1 | 0 sector status space, 1 security register space |
| rd_addr | input | 19 | Read word address or security index |
| rd_data | output | 16 | Read result, registered |

## Verification
Some properties are checked on every cycle. Lock bits only ever rise. A lock request sets at most one bit, and that bit is set after the edge. A refusal always comes with a locked sector and a non-chip operation. A chip-erase mask never includes a locked sector. The user half never regains a cleared bit and stays frozen once locked.

Other behaviour can only be shown by the bench's scenarios. These are the non-uniform address map at the 32K/4K boundary and at the top of the array. They also include the offset-2 status read, the word order of the security register, the data-bit condition of the user-half lock, and the way reset clears all of this state.

// File: rtl/flock_pkg.sv
package flock_pkg;

  typedef enum logic [1:0] {
    REQ_NONE      = 2'd0,
    REQ_LOCK_SECT = 2'd1,
    REQ_PROG_SEC  = 2'd2,
    REQ_LOCK_SEC  = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    QRY_PROGRAM   = 2'd0,
    QRY_SECT_ERA  = 2'd1,
    QRY_CHIP_ERA  = 2'd2,
    QRY_RESERVED  = 2'd3
  } qry_op_e;

  localparam int MAP_PORTS = 3;
  localparam int MAP_REQ   = 0;
  localparam int MAP_QRY   = 1;
  localparam int MAP_RD    = 2;

endpackage

// File: rtl/flock_sector_map.sv
module flock_sector_map #(
  parameter int ADDR_W   = 19,
  parameter int BIG_LG   = 15,
  parameter int SMALL_LG = 12,
  parameter int N_BIG    = 15,
  parameter int SECT_W   = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SECT_W-1:0] idx_o
);
  localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(N_BIG) << BIG_LG;

  // Large sectors sit below BOOT_BASE, small boot sectors above it.
  function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] rel;
    if (a < BOOT_BASE) return SECT_W'(a >> BIG_LG);
    rel = a - BOOT_BASE;
    return SECT_W'(rel >> SMALL_LG) + SECT_W'(N_BIG);
  endfunction

  assign idx_o = sect_of(addr_i);
endmodule

// File: rtl/flock_lock_bank.sv
module flock_lock_bank #(
  parameter int N_SECT = 23,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SECT_W-1:0] set_idx,
  output logic [N_SECT-1:0] lock_vec,
  output logic [N_SECT-1:0] lock_set_vec
);
  for (genvar i = 0; i < N_SECT; i++) begin : g_sect
    assign lock_set_vec[i] = set_en && (set_idx == SECT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lock_vec[i] <= 1'b0;
      else if (lock_set_vec[i]) lock_vec[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/flock_sec_reg.sv
module flock_sec_reg #(
  parameter int              DATA_W     = 16,
  parameter int              HALF_W     = 64,
  parameter logic [HALF_W-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF,
  parameter int              LOCK_BIT   = 1,
  parameter int              PR_IDX_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_en,
  input  logic                lock_cmd,
  input  logic [$clog2(HALF_W/DATA_W)-1:0] prog_idx,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [PR_IDX_W-1:0] rd_idx,
  output logic [DATA_W-1:0]   rd_word,
  output logic [HALF_W-1:0]   hb_q,
  output logic                pr_locked,
  output logic                prog_evt
);
  localparam int HALF_WORDS = HALF_W / DATA_W;
  localparam int IDX_W      = $clog2(HALF_WORDS);
  localparam logic [PR_IDX_W-1:0] IDX_B0   = PR_IDX_W'(HALF_WORDS);
  localparam logic [PR_IDX_W-1:0] IDX_STAT = PR_IDX_W'(2 * HALF_WORDS);

  logic lock_evt;
  logic [DATA_W-1:0] a_words [HALF_WORDS];
  logic [DATA_W-1:0] b_words [HALF_WORDS];

  assign prog_evt = prog_en && !pr_locked;
  assign lock_evt = lock_cmd && !data_i[LOCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pr_locked <= 1'b0;
    else if (lock_evt) pr_locked <= 1'b1;
  end

  for (genvar w = 0; w < HALF_WORDS; w++) begin : g_word
    assign a_words[w] = FACTORY_ID[w*DATA_W +: DATA_W];
    assign b_words[w] = hb_q[w*DATA_W +: DATA_W];

    // Flash-like programming: bits can only be cleared.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        hb_q[w*DATA_W +: DATA_W] <= '1;
      else if (prog_evt && (prog_idx == IDX_W'(w)))
        hb_q[w*DATA_W +: DATA_W] <= hb_q[w*DATA_W +: DATA_W] & data_i;
    end
  end

  function automatic logic [DATA_W-1:0] status_word(input logic locked);
    logic [DATA_W-1:0] s;
    s = '0;
    s[LOCK_BIT] = !locked;
    return s;
  endfunction

  always_comb begin
    rd_word = '0;
    if (rd_idx < IDX_B0)
      rd_word = a_words[rd_idx[IDX_W-1:0]];
    else if (rd_idx < IDX_STAT)
      rd_word = b_words[rd_idx[IDX_W-1:0]];
    else if (rd_idx == IDX_STAT)
      rd_word = status_word(pr_locked);
  end
endmodule

// File: rtl/flock_ctrl.sv
module flock_ctrl
  import flock_pkg::*;
#(
  parameter int                ADDR_W     = 19,
  parameter int                DATA_W     = 16,
  parameter int                BIG_LG     = 15,
  parameter int                SMALL_LG   = 12,
  parameter int                N_BIG      = 15,
  parameter int                N_SMALL    = 8,
  parameter int                HALF_W     = 64,
  parameter logic [HALF_W-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF,
  parameter int                STAT_OFF   = 2,
  parameter int                PR_IDX_W   = 4,
  localparam int               N_SECT     = N_BIG + N_SMALL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              qry_valid,
  input  logic [1:0]        qry_op,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_locked,
  output logic              qry_refuse,
  output logic [N_SECT-1:0] erase_mask,
  input  logic              rd_en,
  input  logic              rd_space,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SECT_W     = $clog2(N_SECT);
  localparam int HALF_WORDS = HALF_W / DATA_W;
  localparam int IDX_W      = $clog2(HALF_WORDS);
  localparam logic [ADDR_W-1:0] BOOT_BASE  = ADDR_W'(N_BIG) << BIG_LG;
  localparam logic [ADDR_W-1:0] BIG_MASK   = (ADDR_W'(1) << BIG_LG) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SMALL_MASK = (ADDR_W'(1) << SMALL_LG) - ADDR_W'(1);

  req_op_e op_req;
  qry_op_e op_qry;
  assign op_req = req_op_e'(req_op);
  assign op_qry = qry_op_e'(qry_op);

  // Sector decoders for the request, query and read addresses.
  logic [ADDR_W-1:0] map_addr [MAP_PORTS];
  logic [SECT_W-1:0] map_idx  [MAP_PORTS];
  assign map_addr[MAP_REQ] = req_addr;
  assign map_addr[MAP_QRY] = qry_addr;
  assign map_addr[MAP_RD]  = rd_addr;

  for (genvar g = 0; g < MAP_PORTS; g++) begin : g_map
    flock_sector_map #(
      .ADDR_W(ADDR_W), .BIG_LG(BIG_LG), .SMALL_LG(SMALL_LG),
      .N_BIG(N_BIG), .SECT_W(SECT_W)
    ) u_map (
      .addr_i(map_addr[g]),
      .idx_o (map_idx[g])
    );
  end

  // Internal events, named for the checker.
  logic              lock_req;
  logic              sec_prog_req;
  logic              sec_lock_req;
  logic [N_SECT-1:0] lock_vec;
  logic [N_SECT-1:0] lock_set_vec;
  logic [HALF_W-1:0] hb_q;
  logic              pr_locked;
  logic              prog_evt;
  logic [DATA_W-1:0] pr_word;
  logic [DATA_W-1:0] stat_word;

  assign lock_req     = req_valid && (op_req == REQ_LOCK_SECT);
  assign sec_prog_req = req_valid && (op_req == REQ_PROG_SEC);
  assign sec_lock_req = req_valid && (op_req == REQ_LOCK_SEC);

  flock_lock_bank #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_en      (lock_req),
    .set_idx     (map_idx[MAP_REQ]),
    .lock_vec    (lock_vec),
    .lock_set_vec(lock_set_vec)
  );

  flock_sec_reg #(
    .DATA_W(DATA_W), .HALF_W(HALF_W), .FACTORY_ID(FACTORY_ID),
    .LOCK_BIT(1), .PR_IDX_W(PR_IDX_W)
  ) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_en  (sec_prog_req),
    .lock_cmd (sec_lock_req),
    .prog_idx (req_addr[IDX_W-1:0]),
    .data_i   (req_data),
    .rd_idx   (rd_addr[PR_IDX_W-1:0]),
    .rd_word  (pr_word),
    .hb_q     (hb_q),
    .pr_locked(pr_locked),
    .prog_evt (prog_evt)
  );

  // Offset of an address within its own sector equals the status offset.
  function automatic logic stat_hit(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = (a < BOOT_BASE) ? (a & BIG_MASK) : (a & SMALL_MASK);
    return off == ADDR_W'(STAT_OFF);
  endfunction

  assign qry_locked = lock_vec[map_idx[MAP_QRY]];
  assign qry_refuse = qry_valid && qry_locked &&
                      ((op_qry == QRY_PROGRAM) || (op_qry == QRY_SECT_ERA));
  assign erase_mask = (qry_valid && (op_qry == QRY_CHIP_ERA)) ? ~lock_vec : '0;

  assign stat_word = DATA_W'(stat_hit(rd_addr) && lock_vec[map_idx[MAP_RD]]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_space ? pr_word : stat_word;
  end
endmodule

// File: rtl/flock_ctrl_chk.sv
module flock_ctrl_chk #(
  parameter int N_SECT = 23,
  parameter int HALF_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              qry_valid,
  input logic [1:0]        qry_op,
  input logic              qry_locked,
  input logic              qry_refuse,
  input logic [N_SECT-1:0] erase_mask,
  input logic [N_SECT-1:0] lock_vec,
  input logic [N_SECT-1:0] lock_set_vec,
  input logic [HALF_W-1:0] hb_q,
  input logic              pr_locked
);
  p_lock_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_set_vec));

  p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|lock_set_vec) |=> ((lock_vec & $past(lock_set_vec)) == $past(lock_set_vec)));

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(lock_vec) & ~lock_vec) == '0));

  p_refuse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qry_refuse |-> (qry_valid && qry_locked && (qry_op != 2'd2) && (qry_op != 2'd3)));

  p_chip_no_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_op == 2'd2) |-> (!qry_refuse && ((erase_mask & lock_vec) == '0)));

  p_halfb_clear_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((hb_q & ~$past(hb_q)) == '0));

  p_halfb_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pr_locked |=> ($stable(hb_q) && pr_locked));
endmodule

bind flock_ctrl flock_ctrl_chk #(.N_SECT(N_SECT), .HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .qry_valid   (qry_valid),
  .qry_op      (qry_op),
  .qry_locked  (qry_locked),
  .qry_refuse  (qry_refuse),
  .erase_mask  (erase_mask),
  .lock_vec    (lock_vec),
  .lock_set_vec(lock_set_vec),
  .hb_q        (hb_q),
  .pr_locked   (pr_locked)
);

// File: tb/flock_ctrl_tb.sv
module flock_ctrl_tb;
  localparam logic [63:0] FID = 64'h0123_4567_89AB_CDEF;
  localparam logic [22:0] ALL = 23'h7F_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        qry_valid = 1'b0;
  logic [1:0]  qry_op = 2'd0;
  logic [18:0] qry_addr = '0;
  logic        qry_locked;
  logic        qry_refuse;
  logic [22:0] erase_mask;
  logic        rd_en = 1'b0;
  logic        rd_space = 1'b0;
  logic [18:0] rd_addr = '0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .qry_valid(qry_valid), .qry_op(qry_op), .qry_addr(qry_addr),
    .qry_locked(qry_locked), .qry_refuse(qry_refuse), .erase_mask(erase_mask),
    .rd_en(rd_en), .rd_space(rd_space), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic [18:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd0;
  endtask

  task automatic query(input logic v, input logic [1:0] op, input logic [18:0] a);
    @(negedge clk);
    qry_valid = v; qry_op = op; qry_addr = a;
    #2;
  endtask

  task automatic rd(input logic sp, input logic [18:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_space = sp; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic t_reset_state;
    logic [15:0] d;
    query(1'b1, 2'd2, 19'h00000);
    chk("R1 mask after reset", 32'(erase_mask), 32'(ALL));
    query(1'b1, 2'd0, 19'h7FFFF);
    chk("R1 top sector unlocked", 32'(qry_locked), 0);
    rd(1'b1, 19'd8, d);
    chk("R1 sec status word", 32'(d), 32'h0002);
    for (int i = 4; i < 8; i++) begin
      rd(1'b1, 19'(i), d);
      chk("R1 user half erased", 32'(d), 32'hFFFF);
    end
  endtask

  task automatic t_map_lock;
    do_req(2'd1, 19'h77FFF, 16'h0);   // sector 14, last large one
    query(1'b0, 2'd0, 19'h70000);
    chk("R3 sector14 locked", 32'(qry_locked), 1);
    query(1'b0, 2'd0, 19'h78000);
    chk("R2 sector15 separate", 32'(qry_locked), 0);
    query(1'b0, 2'd0, 19'h6FFFF);
    chk("R2 sector13 separate", 32'(qry_locked), 0);
    do_req(2'd1, 19'h7F000, 16'h0);   // sector 22, top 4K
    query(1'b0, 2'd0, 19'h7FFFF);
    chk("R2 sector22 locked", 32'(qry_locked), 1);
    query(1'b0, 2'd0, 19'h7EFFF);
    chk("R2 sector21 separate", 32'(qry_locked), 0);
    query(1'b1, 2'd2, 19'h0);
    chk("R3 only two locked", 32'(erase_mask), 32'(ALL & ~((23'd1 << 14) | (23'd1 << 22))));
  endtask

  task automatic t_refuse;
    query(1'b1, 2'd0, 19'h70010);
    chk("R5 program locked refused", 32'(qry_refuse), 1);
    query(1'b1, 2'd1, 19'h7F800);
    chk("R5 erase locked refused", 32'(qry_refuse), 1);
    query(1'b1, 2'd0, 19'h00000);
    chk("R5 program unlocked ok", 32'(qry_refuse), 0);
    query(1'b0, 2'd0, 19'h70010);
    chk("R5 no valid no refuse", 32'(qry_refuse), 0);
  endtask

  task automatic t_chip;
    query(1'b1, 2'd2, 19'h70000);
    chk("R6 chip not refused", 32'(qry_refuse), 0);
    chk("R6 chip mask", 32'(erase_mask), 32'(ALL & ~((23'd1 << 14) | (23'd1 << 22))));
    query(1'b1, 2'd3, 19'h70000);
    chk("R6 reserved no refuse", 32'(qry_refuse), 0);
    chk("R6 reserved mask zero", 32'(erase_mask), 0);
    query(1'b1, 2'd0, 19'h70000);
    chk("R6 program mask zero", 32'(erase_mask), 0);
  endtask

  task automatic t_status_read;
    logic [15:0] d;
    rd(1'b0, 19'h70002, d);
    chk("R7 locked big status", 32'(d), 1);
    rd(1'b0, 19'h78002, d);
    chk("R7 unlocked small status", 32'(d), 0);
    rd(1'b0, 19'h7F002, d);
    chk("R7 locked small status", 32'(d), 1);
    rd(1'b0, 19'h70003, d);
    chk("R7 wrong offset", 32'(d), 0);
  endtask

  task automatic t_sticky;
    do_req(2'd0, 19'h70000, 16'hFFFF);
    do_req(2'd1, 19'h70000, 16'h0);
    do_req(2'd3, 19'h70000, 16'h0002);
    query(1'b0, 2'd0, 19'h70000);
    chk("R4 lock persists", 32'(qry_locked), 1);
    query(1'b1, 2'd2, 19'h0);
    chk("R4 mask unchanged", 32'(erase_mask), 32'(ALL & ~((23'd1 << 14) | (23'd1 << 22))));
  endtask

  task automatic t_sec_prog;
    logic [15:0] d;
    do_req(2'd2, 19'd1, 16'h00F0);
    rd(1'b1, 19'd5, d);
    chk("R9 and with ones", 32'(d), 32'h00F0);
    do_req(2'd2, 19'd1, 16'hFF0F);
    rd(1'b1, 19'd5, d);
    chk("R9 clear only", 32'(d), 0);
    do_req(2'd2, 19'd2, 16'hA5A5);
    do_req(2'd2, 19'd2, 16'hFFFF);
    rd(1'b1, 19'd6, d);
    chk("R9 no set back", 32'(d), 32'hA5A5);
    for (int i = 0; i < 4; i++) begin
      rd(1'b1, 19'(i), d);
      chk("R8 factory word", 32'(d), 32'(FID[i*16 +: 16]));
    end
    rd(1'b1, 19'd9, d);
    chk("R8 out of range", 32'(d), 0);
  endtask

  task automatic t_sec_lock;
    logic [15:0] d;
    do_req(2'd3, 19'd0, 16'h0002);
    rd(1'b1, 19'd8, d);
    chk("R10 bit1 set no lock", 32'(d), 32'h0002);
    do_req(2'd2, 19'd3, 16'h1234);
    rd(1'b1, 19'd7, d);
    chk("R10 still writable", 32'(d), 32'h1234);
    do_req(2'd3, 19'd0, 16'hFFFD);
    rd(1'b1, 19'd8, d);
    chk("R10 locked status", 32'(d), 0);
    do_req(2'd2, 19'd3, 16'h0000);
    rd(1'b1, 19'd7, d);
    chk("R10 program ignored", 32'(d), 32'h1234);
  endtask

  task automatic t_reset_clear;
    logic [15:0] d;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    query(1'b0, 2'd0, 19'h70000);
    chk("R11 sector lock cleared", 32'(qry_locked), 0);
    query(1'b1, 2'd2, 19'h0);
    chk("R11 full mask", 32'(erase_mask), 32'(ALL));
    rd(1'b1, 19'd8, d);
    chk("R11 sec unlocked", 32'(d), 32'h0002);
    rd(1'b1, 19'd7, d);
    chk("R11 user half erased", 32'(d), 32'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_map_lock();
    t_refuse();
    t_chip();
    t_status_read();
    t_sticky();
    t_sec_prog();
    t_sec_lock();
    t_reset_clear();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule